// File: doc/BRIEF.md
# ADC Auto-Trigger Start Selector

This block decides when an analog-to-digital conversion should begin. It watches seven event flags from neighbouring peripherals and the converter's own conversion-complete flag. A 3-bit select field picks one of these eight signals. The block then issues a single-cycle start pulse when the chosen signal rises, as long as auto-triggering is on, the converter is enabled and no conversion is already running.

Edge detection works on the output of the multiplexer, not on each source separately. As a result, moving the select from a low source to a high source counts as a rising edge. The one exception is a move into free-running mode (select 000): that move never produces an edge, even if the conversion-complete flag is already high. In free-running mode, each rise of the conversion-complete flag starts the next conversion.

A small state machine drives the output. It has three states:
- **ST_IDLE**: auto-triggering or the converter is disabled.
- **ST_ARMED**: the block is waiting for an edge.
- **ST_FIRE**: the start pulse is being driven.

Its transitions are:
- **T_DISABLE**: any state goes to ST_IDLE when either enable is low.
- **T_EDGE**: ST_IDLE, ST_ARMED or ST_FIRE goes to ST_FIRE when an edge is seen while the converter is idle.
- **T_WAIT**: any state goes to ST_ARMED when both enables are high and no qualifying edge is seen.

Top module: `adc_trig_sel`

## Requirements
- R1: The select value picks the watched signal as follows:
  - 000: `conv_done`.
  - 001: `evt_flags[0]` (analog comparator).
  - 010: `evt_flags[1]` (external interrupt 0).
  - 011: `evt_flags[2]` (timer0 compare).
  - 100: `evt_flags[3]` (timer0 overflow).
  - 101: `evt_flags[4]` (timer1 compare B).
  - 110: `evt_flags[5]` (timer1 overflow).
  - 111: `evt_flags[6]` (timer1 capture).
  
  Flags that are not selected have no effect on `start_o`.
- R2: While `auto_en` is low, no start pulse is produced, whatever the select value and flags.
- R3: A start comes only from a low-to-high change of the selected signal. A signal that stays high produces no further pulses.
- R4: Changing the select from a source whose flag is low to a source whose flag is high produces a start pulse.
- R5: While `conv_en` is low, no start pulse is produced.
- R6: Changing the select into 000 never produces a start pulse, even when `conv_done` is high.
- R7: In mode 000, each rise of `conv_done` produces a start pulse.
- R8: An edge seen while `conv_busy` is high is dropped and is not held for later.
- R9: `start_o` is high for exactly one cycle. It rises in the cycle after the clock edge at which the qualifying input edge was sampled.
- R10: A synchronous active-high `rst` clears the edge history and drives `start_o` low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 3 | Trigger source select |
| auto_en | input | 1 | Auto-trigger enable |
| conv_en | input | 1 | Converter enable |
| evt_flags | input | 7 | Candidate event flags (bit k is selected by select value k+1) |
| conv_done | input | 1 | Conversion-complete flag, used by free-running mode |
| conv_busy | input | 1 | Converter busy indication |
| start_o | output | 1 | One-cycle conversion start pulse |

## Verification
The hardest case to reach from the ports is a select change into free-running mode that lands while `conv_done` is already high. This matters because the only false edge the block must suppress comes from the select moving, not from any flag moving. The stimulus first parks the select on a timer source whose flag is low and raises `conv_done`. It then switches the select to 000 in one cycle. After that it lowers and raises `conv_done` again to show that free-running restarts still fire. A busy window that coincides with an edge is also built on purpose. The flag is held high after busy drops, which shows that the lost edge is not replayed.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } trig_state_t;
endpackage

// File: rtl/adc_trig_mux.sv
module adc_trig_mux #(
    parameter int NUM_EVT = 7,
    parameter int SEL_W   = $clog2(NUM_EVT + 1)
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] flags,
    input  logic               done,
    output logic               mux_o
);
    localparam int NUM_SRC = NUM_EVT + 1;

    // Source 0 is the completion flag; source k+1 is event flag k.
    logic [NUM_SRC-1:0] src_vec;

    assign src_vec[0] = done;
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_src
        assign src_vec[k+1] = flags[k];
    end

    always_comb begin
        mux_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) mux_o = src_vec[i];
        end
    end
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             mux_in,
    output logic             edge_o
);
    logic             prev_q;
    logic [SEL_W-1:0] sel_q;
    logic             enter_free;

    // Entering mode 0 must not look like an edge.
    assign enter_free = (sel == '0) && (sel_q != '0);
    assign edge_o     = mux_in && !prev_q && !enter_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            prev_q <= mux_in;
            sel_q  <= sel;
        end
    end

    // A level that stays high yields no second edge (R3).
    p_level_no_repeat_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(mux_in) && mux_in) |-> !edge_o);
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_trig_pkg::*;
#(
    parameter int NUM_EVT = 7,
    parameter int SEL_W   = $clog2(NUM_EVT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               auto_en,
    input  logic               conv_en,
    input  logic [NUM_EVT-1:0] evt_flags,
    input  logic               conv_done,
    input  logic               conv_busy,
    output logic               start_o
);
    trig_state_t state_q, state_d;
    logic        mux_sig;
    logic        edge_sig;

    adc_trig_mux #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_mux (
        .sel   (src_sel),
        .flags (evt_flags),
        .done  (conv_done),
        .mux_o (mux_sig)
    );

    adc_trig_edge #(.SEL_W(SEL_W)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sel    (src_sel),
        .mux_in (mux_sig),
        .edge_o (edge_sig)
    );

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_ARMED, ST_FIRE: begin
                if (!(auto_en && conv_en))        state_d = ST_IDLE;   // T_DISABLE
                else if (edge_sig && !conv_busy)  state_d = ST_FIRE;   // T_EDGE
                else                              state_d = ST_ARMED;  // T_WAIT
            end
            default:                              state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output process
    always_comb begin
        start_o = (state_q == ST_FIRE);
    end

    p_auto_off_r2: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> !start_o);

    p_conv_off_r5: assert property (@(posedge clk) disable iff (rst)
        !conv_en |=> !start_o);

    p_busy_drop_r8: assert property (@(posedge clk) disable iff (rst)
        conv_busy |=> !start_o);

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !start_o);

    p_free_entry_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && src_sel == '0 && $past(src_sel) != '0) |=> !start_o);

    p_free_restart_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && auto_en && conv_en && !conv_busy && src_sel == '0 &&
         $past(src_sel) == '0 && conv_done && !$past(conv_done)) |=> start_o);
endmodule

// File: tb/sim_adc_trig_sel.sv
module sim_adc_trig_sel;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] src_sel;
    logic       auto_en, conv_en;
    logic [6:0] evt_flags;
    logic       conv_done, conv_busy;
    logic       start_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Scoreboard queues: expected value and requirement tag
    bit    exp_q[$];
    string tag_q[$];

    // Independent reference state
    bit       m_prev = 0;
    bit [2:0] m_sel  = 0;

    always #4 clk = ~clk;   // 125 MHz

    adc_trig_sel u0 (
        .clk(clk), .rst(rst), .src_sel(src_sel), .auto_en(auto_en),
        .conv_en(conv_en), .evt_flags(evt_flags), .conv_done(conv_done),
        .conv_busy(conv_busy), .start_o(start_o)
    );

    function automatic bit pick(input bit [2:0] s, input bit [6:0] f, input bit d);
        if (s == 3'd0) return d;
        return f[s - 3'd1];
    endfunction

    // Driver: drives one cycle of stimulus and pushes the expected start
    task automatic step(input bit r, input bit [2:0] s, input bit a, input bit e,
                        input bit [6:0] f, input bit d, input bit b, input string tag);
        bit m, x;
        @(negedge clk);
        rst = r; src_sel = s; auto_en = a; conv_en = e;
        evt_flags = f; conv_done = d; conv_busy = b;
        m = pick(s, f, d);
        if (r) begin
            x = 0; m_prev = 0; m_sel = 0;
        end else begin
            x = a && e && !b && m && !m_prev && !(s == 3'd0 && m_sel != 3'd0);
            m_prev = m; m_sel = s;
        end
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                bit    x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (start_o !== x) begin
                    n_fail++;
                    $display("FAIL %s: start_o=%b expected=%b", t, start_o, x);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; src_sel = 0; auto_en = 0; conv_en = 0;
        evt_flags = 0; conv_done = 0; conv_busy = 0;
        repeat (3) step(1, 0, 0, 0, 7'h00, 0, 0, "R10");
        // R10: reset state visible at the port
        @(negedge clk);
        n_checks++;
        if (start_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: start_o=%b expected=0", start_o);
        end

        // R1 / R3: each source mapped, others high do not matter, level held
        for (int k = 1; k <= 7; k++) begin
            step(0, 3'(k), 1, 1, 7'h7F & ~(7'h01 << (k-1)), 0, 0, "R1");
            step(0, 3'(k), 1, 1, 7'h7F, 0, 0, "R1");
            step(0, 3'(k), 1, 1, 7'h7F, 0, 0, "R3");
            step(0, 3'(k), 1, 1, 7'h7F, 0, 0, "R3");
            step(0, 3'(k), 1, 1, 7'h00, 0, 0, "R9");
        end

        // R4: select moves from low source to high source
        step(0, 3'd1, 1, 1, 7'b0000010, 0, 0, "R4");
        step(0, 3'd2, 1, 1, 7'b0000010, 0, 0, "R4");
        step(0, 3'd2, 1, 1, 7'b0000010, 0, 0, "R9");

        // R2: auto disabled, edge ignored and not replayed
        step(0, 3'd3, 0, 1, 7'b0000000, 0, 0, "R2");
        step(0, 3'd3, 0, 1, 7'b0000100, 0, 0, "R2");
        step(0, 3'd3, 1, 1, 7'b0000100, 0, 0, "R2");

        // R5: converter disabled
        step(0, 3'd4, 1, 0, 7'b0000000, 0, 0, "R5");
        step(0, 3'd4, 1, 0, 7'b0001000, 0, 0, "R5");
        step(0, 3'd4, 1, 1, 7'b0001000, 0, 0, "R5");

        // R8: edge during busy is dropped
        step(0, 3'd5, 1, 1, 7'b0000000, 0, 1, "R8");
        step(0, 3'd5, 1, 1, 7'b0010000, 0, 1, "R8");
        step(0, 3'd5, 1, 1, 7'b0010000, 0, 0, "R8");
        step(0, 3'd5, 1, 1, 7'b0000000, 0, 0, "R8");
        step(0, 3'd5, 1, 1, 7'b0010000, 0, 0, "R8");

        // R6: entering free running with done already high
        step(0, 3'd3, 1, 1, 7'b0000000, 1, 0, "R6");
        step(0, 3'd0, 1, 1, 7'b0000000, 1, 0, "R6");
        step(0, 3'd0, 1, 1, 7'b0000000, 1, 0, "R6");

        // R7: free-running restarts on each done rise
        for (int j = 0; j < 3; j++) begin
            step(0, 3'd0, 1, 1, 7'h7F, 0, 0, "R7");
            step(0, 3'd0, 1, 1, 7'h7F, 1, 0, "R7");
            step(0, 3'd0, 1, 1, 7'h7F, 1, 1, "R9");
        end

        // R10: reset coinciding with a rising flag
        step(0, 3'd6, 1, 1, 7'b0000000, 0, 0, "R10");
        step(1, 3'd6, 1, 1, 7'b0100000, 0, 0, "R10");
        step(0, 3'd6, 1, 1, 7'b0000000, 0, 0, "R10");
        step(0, 3'd6, 1, 1, 7'b0100000, 0, 0, "R10");
        step(0, 3'd6, 1, 1, 7'b0000000, 0, 0, "R9");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule